// File: doc/BRIEF.md
# One-Time-Programmable Wiper Setting Controller

This block keeps the tap code of a 64-position digital potentiometer. The code can be rewritten any number of times. A single fuse-programming event then freezes it for good. Fuse state is held inside the block: six data fuses, a test fuse and a lock fuse. The host writes a code, or a code together with a program request. The block then runs a timed blow sequence and raises a busy flag for its whole length.

When the blow ends, two testbench-driven inputs decide the result: whether the test fuse blew and whether the data fuses blew. The block then reports one of four outcomes on a two-bit status: ready, test-fuse failure, fatal failure or success. After that single attempt, no further adjustment or program request is honoured. A synchronous power-on input reloads the wiper. It loads the fused code if the lock fuse is set, and midscale otherwise.

Top module: `otp_wiper_ctrl`

## Requirements
- R1: When `por` is high at a clock edge and the lock fuse is not set, the wiper code becomes midscale, 0x20 for 6 bits.
- R2: Before any program attempt, when not busy, a write with `wr_prog`=0 loads `wr_data` into the wiper at that edge, and any number of such writes is accepted.
- R3: A write with `wr_prog`=1 while ready loads `wr_data` into the wiper and raises `busy` for exactly `BLOW_CYCLES` cycles.
- R4: Writes that arrive while `busy` is high leave the wiper unchanged, and `status` reads 00 during the blow.
- R5: If `test_fuse_ok` and `data_fuse_ok` are both 1 at the final blow edge, the lock fuse is set, the wiper code is fused, and `status` becomes 11.
- R6: If `test_fuse_ok` is 0 at the final blow edge, `status` becomes 01. If `test_fuse_ok` is 1 and `data_fuse_ok` is 0, `status` becomes 10. In both cases the wiper stays at the committed code until the next power-on.
- R7: After any program attempt (status 01, 10 or 11), all writes, with or without `wr_prog`, are ignored: the wiper does not change and `busy` stays low.
- R8: When `por` is high with the lock fuse set, the wiper loads the fused code. `status` keeps its value across power-on.
- R9: `status` encoding: 00 = ready to program, 01 = test fuse not blown, 10 = fatal error, 11 = programmed successfully.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Synchronous power-on reload, active high |
| wr_en | input | 1 | Write request strobe |
| wr_data | input | CODE_W | Requested tap code |
| wr_prog | input | 1 | Program request accompanying a write |
| test_fuse_ok | input | 1 | Test fuse blew, sampled at the final blow edge |
| data_fuse_ok | input | 1 | Data fuses blew, sampled at the final blow edge |
| wiper | output | CODE_W | Active tap code |
| status | output | 2 | Validation bits |
| busy | output | 1 | Fuse blow in progress |

## Verification
Several properties are checked on every cycle:
- the wiper holds steady throughout a blow;
- status stays at ready during a blow;
- a nonzero status never returns to ready;
- a locked part never changes its fused code or its wiper;
- busy rises only after a program request.

Some behaviour can only be shown by the bench's scenarios:
- the exact blow length;
- the three outcome encodings, driven through three instances with different fuse results;
- the midscale and fused-code reloads at power-on;
- the random run of free writes before programming.

// File: rtl/otp_wiper_ctrl.sv
module otp_wiper_ctrl #(
  parameter int CODE_W      = 6,
  parameter int BLOW_CYCLES = 20_000_000
) (
  input  logic              clk,
  input  logic              por,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_data,
  input  logic              wr_prog,
  input  logic              test_fuse_ok,
  input  logic              data_fuse_ok,
  output logic [CODE_W-1:0] wiper,
  output logic [1:0]        status,
  output logic              busy
);
  localparam int CNT_W = $clog2(BLOW_CYCLES + 1);
  localparam logic [CODE_W-1:0] MIDSCALE = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CNT_W-1:0]  LAST     = CNT_W'(BLOW_CYCLES - 1);

  logic [CODE_W-1:0] fuse_data = '0;
  logic              fuse_test = 1'b0;
  logic              fuse_lock = 1'b0;
  logic              spent     = 1'b0;
  logic [CNT_W-1:0]  cnt       = '0;
  logic [CODE_W-1:0] wiper_q   = MIDSCALE;
  logic              busy_q    = 1'b0;

  wire accept = wr_en && !busy_q && !spent && !fuse_lock;
  wire done   = busy_q && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (por) begin
      wiper_q <= fuse_lock ? fuse_data : MIDSCALE;
      busy_q  <= 1'b0;
      cnt     <= '0;
      if (busy_q) spent <= 1'b1;
    end else begin
      if (accept) begin
        wiper_q <= wr_data;
        if (wr_prog) begin
          busy_q <= 1'b1;
          cnt    <= '0;
        end
      end
      if (busy_q) cnt <= cnt + CNT_W'(1);
      if (done) begin
        busy_q    <= 1'b0;
        spent     <= 1'b1;
        fuse_test <= test_fuse_ok;
        if (test_fuse_ok && data_fuse_ok) begin
          fuse_lock <= 1'b1;
          fuse_data <= wiper_q;
        end
      end
    end
  end

  assign wiper  = wiper_q;
  assign busy   = busy_q;
  assign status = fuse_lock ? 2'b11 : !spent ? 2'b00 : fuse_test ? 2'b10 : 2'b01;

  // R4
  wiper_hold_blow_chk: assert property (@(posedge clk) disable iff (por)
    busy |=> $stable(wiper));
  // R4
  ready_during_blow_chk: assert property (@(posedge clk) disable iff (por)
    busy |-> status == 2'b00);
  // R7
  attempt_sticky_chk: assert property (@(posedge clk) disable iff (por)
    status != 2'b00 |=> status != 2'b00 && !busy);
  // R5
  fused_code_frozen_chk: assert property (@(posedge clk) disable iff (por)
    fuse_lock |=> $stable(fuse_data) && $stable(wiper));
  // R3
  blow_needs_request_chk: assert property (@(posedge clk) disable iff (por)
    $rose(busy) |-> $past(wr_en && wr_prog));
endmodule

// File: tb/tb_otp_wiper_ctrl.sv
module tb_otp_wiper_ctrl;
  localparam int W = 6;
  localparam int N = 40;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         por = 1'b0, wr_en = 1'b0, wr_prog = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] w_s, w_t, w_f;
  logic [1:0]   s_s, s_t, s_f;
  logic         b_s, b_t, b_f;
  int errors = 0, checks = 0;

  otp_wiper_ctrl #(.CODE_W(W), .BLOW_CYCLES(N)) dut (
    .clk(clk), .por(por), .wr_en(wr_en), .wr_data(wr_data), .wr_prog(wr_prog),
    .test_fuse_ok(1'b1), .data_fuse_ok(1'b1), .wiper(w_s), .status(s_s), .busy(b_s));
  otp_wiper_ctrl #(.CODE_W(W), .BLOW_CYCLES(N)) dut_t (
    .clk(clk), .por(por), .wr_en(wr_en), .wr_data(wr_data), .wr_prog(wr_prog),
    .test_fuse_ok(1'b0), .data_fuse_ok(1'b1), .wiper(w_t), .status(s_t), .busy(b_t));
  otp_wiper_ctrl #(.CODE_W(W), .BLOW_CYCLES(N)) dut_f (
    .clk(clk), .por(por), .wr_en(wr_en), .wr_data(wr_data), .wr_prog(wr_prog),
    .test_fuse_ok(1'b1), .data_fuse_ok(1'b0), .wiper(w_f), .status(s_f), .busy(b_f));

  function automatic logic [W-1:0] midscale();
    return W'(1) << (W - 1);
  endfunction

  function automatic logic [W-1:0] after_write(logic [W-1:0] cur, logic en,
                                               logic [W-1:0] d, logic open);
    return (en && open) ? d : cur;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] exp_w;
    logic [W-1:0] code;
    void'($urandom(32'd1234));
    step();
    por = 1'b1; step(); por = 1'b0;
    // R1 R9: power-on state
    chk("R1", w_s, midscale()); chk("R1", w_t, midscale());
    chk("R9", s_s, 0); chk("R9", b_s, 0);
    exp_w = midscale();

    // R2: random free writes
    for (int i = 0; i < 60; i++) begin
      wr_en = 1'($urandom_range(0, 1));
      wr_data = W'($urandom);
      wr_prog = 1'b0;
      exp_w = after_write(exp_w, wr_en, wr_data, 1'b1);
      step();
      chk("R2", w_s, exp_w);
      chk("R2", w_f, exp_w);
    end
    // R2: extreme codes
    wr_en = 1'b1; wr_data = '1; step(); chk("R2", w_s, 6'h3F);
    wr_data = '0; step(); chk("R2", w_s, 6'h00);
    wr_en = 1'b0;
    // R1: reload before programming returns to midscale
    por = 1'b1; step(); por = 1'b0;
    chk("R1", w_s, 6'h20); chk("R9", s_s, 0);

    // R3: program request
    code = 6'h2B;
    wr_en = 1'b1; wr_data = code; wr_prog = 1'b1; step();
    wr_prog = 1'b0;
    chk("R3", b_s, 1); chk("R3", w_s, code);
    for (int i = 1; i < N; i++) begin
      wr_en = 1'($urandom_range(0, 1));
      wr_data = W'($urandom);
      wr_prog = 1'($urandom_range(0, 1));
      step();
      // R4: writes during blow ignored
      chk("R3", b_s, 1); chk("R4", w_s, code); chk("R4", s_s, 0);
    end
    wr_en = 1'b0; wr_prog = 1'b0;
    step();
    chk("R3", b_s, 0);
    // R5 R6: outcomes
    chk("R5", s_s, 3); chk("R5", w_s, code);
    chk("R6", s_t, 1); chk("R6", s_f, 2);
    chk("R6", w_t, code); chk("R6", w_f, code);

    // R7: everything ignored after the attempt
    for (int i = 0; i < 20; i++) begin
      wr_en = 1'b1;
      wr_data = W'($urandom);
      wr_prog = 1'($urandom_range(0, 1));
      step();
      chk("R7", w_s, code); chk("R7", w_t, code); chk("R7", w_f, code);
      chk("R7", b_s | b_t | b_f, 0);
    end
    wr_en = 1'b0; wr_prog = 1'b0;

    // R8: reload after the attempt
    por = 1'b1; step(); por = 1'b0;
    chk("R8", w_s, code); chk("R8", s_s, 3);
    chk("R1", w_t, midscale()); chk("R8", s_t, 1);
    chk("R1", w_f, midscale()); chk("R8", s_f, 2);
    wr_en = 1'b1; wr_data = 6'h05; wr_prog = 1'b1; step();
    wr_en = 1'b0; wr_prog = 1'b0; step();
    chk("R7", w_s, code); chk("R7", w_f, midscale()); chk("R7", b_f, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule